// File: doc/BRIEF.md
# Half-Rate Boxcar Filter Chain for Complex Samples

This block low-pass filters a stream of complex integer samples, such as the I and Q products of a lock-in detector, and uses no multipliers. It is a chain of identical stages. Each stage keeps a ring of its most recent `TAPS` inputs and a running total. For every accepted sample the total gains the new value and loses the value that leaves the window. After the update a stage emits the total, scaled by an arithmetic right shift, on every second input. The next stage therefore runs at half the rate. The real and imaginary lanes share the control path but are computed apart.

Samples enter through a valid/ready port and leave through a valid/ready port at the end of the chain. A stalled output holds its value. While the output is stalled the whole chain freezes and the input is not accepted. A new sample cannot enter unless the output register is empty or is being drained in the same cycle. Each stage registers its output, so a result leaves `STAGES` clock edges after the input that completes it, provided nothing stalls.

Top module: `halfrate_boxcar_chain`

## Requirements
- R1: A synchronous reset (`rst` high) clears every history slot, running total and ring index to zero. It also drives `out_valid` low, so the outputs that follow reset treat all earlier inputs as zero.
- R2: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A sample is taken on a rising edge where `in_valid` and `in_ready` are both high.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_re` and `out_im` keep their values on the next cycle.
- R4: Each stage's output is the sum of its last `TAPS` inputs, with zeros standing in for slots not yet written since reset, arithmetically shifted right by `SHIFT`. The shift rounds toward minus infinity.
- R5: A stage's ring index counts 0 to `TAPS`-1 and wraps to 0. The stage emits a sample only when its index after the update is even. With an even `TAPS`, the chain gives exactly one output per 2^`STAGES` accepted inputs, and the first output follows the 2^`STAGES`-th input after reset.
- R6: The real and imaginary lanes are independent: a value in one lane never affects the other lane's output.
- R7: With `SHIFT` = log2(`TAPS`), a constant input c gives outputs equal to c from the first output at or after the `TAPS`*2^`STAGES`-th input onward. This holds for c at both ends of the signed input range.
- R8: The totals carry `IN_W` + log2(`TAPS`) bits per stage, so they never overflow. A stage's output width grows by log2(`TAPS`) - `SHIFT` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Chain can take a sample this cycle |
| in_re | input | IN_W | Signed real part of the input |
| in_im | input | IN_W | Signed imaginary part of the input |
| out_valid | output | 1 | Filtered sample available |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_re | output | OUT_W | Signed real part of the output |
| out_im | output | OUT_W | Signed imaginary part of the output |

## Verification
The bound properties check the handshake on every cycle: the ready rule, the holding of a stalled output, and the idle output after reset. They also keep a running count of transfers on both sides, which shows the output rate never exceeds one per 2^`STAGES` inputs. The numeric results need the bench's scenarios: the windowed sums, zero history after a reset in mid-stream, lane independence, settling to a constant and full-scale extremes. The bench compares every output against a model that adds up each stage's window directly.

// File: rtl/boxcar_pkg.sv
package boxcar_pkg;
  // bits added to a running total that holds `taps` samples
  function automatic int growth_bits(input int taps);
    return $clog2(taps);
  endfunction

  // data width at the input of stage k
  function automatic int lane_width(input int in_w, input int taps, input int shift, input int k);
    return in_w + k * (growth_bits(taps) - shift);
  endfunction
endpackage

// File: rtl/boxcar_ring.sv
module boxcar_ring #(
  parameter int DEPTH = 4,
  parameter int DW    = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] oldest,
  output logic          next_even
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] slot [DEPTH];
  logic [IW-1:0] wptr;
  logic [IW-1:0] wptr_nxt;

  assign wptr_nxt  = (wptr == IW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
  assign oldest    = slot[wptr];
  assign next_even = ~wptr_nxt[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (we) begin
      slot[wptr] <= wdata;
      wptr       <= wptr_nxt;
    end
  end
endmodule

// File: rtl/boxcar_half_stage.sv
module boxcar_half_stage #(
  parameter int TAPS  = 4,
  parameter int WI    = 12,
  parameter int SHIFT = 2
) (
  input  logic                                                  clk,
  input  logic                                                  rst,
  input  logic                                                  en,
  input  logic                                                  i_vld,
  input  logic signed [WI-1:0]                                  i_re,
  input  logic signed [WI-1:0]                                  i_im,
  output logic                                                  o_vld,
  output logic signed [WI+boxcar_pkg::growth_bits(TAPS)-SHIFT-1:0] o_re,
  output logic signed [WI+boxcar_pkg::growth_bits(TAPS)-SHIFT-1:0] o_im
);
  localparam int AW = WI + boxcar_pkg::growth_bits(TAPS);
  localparam int WO = AW - SHIFT;

  logic                 take;
  logic                 emit;
  logic [2*WI-1:0]      old_pair;
  logic signed [WI-1:0] old_re, old_im;
  logic signed [AW-1:0] tot_re, tot_im;
  logic signed [AW-1:0] tot_re_n, tot_im_n;

  assign take = en && i_vld;

  boxcar_ring #(.DEPTH(TAPS), .DW(2*WI)) u_ring (
    .clk       (clk),
    .rst       (rst),
    .we        (take),
    .wdata     ({i_re, i_im}),
    .oldest    (old_pair),
    .next_even (emit)
  );

  assign old_re   = old_pair[2*WI-1:WI];
  assign old_im   = old_pair[WI-1:0];
  assign tot_re_n = tot_re + AW'(i_re) - AW'(old_re);
  assign tot_im_n = tot_im + AW'(i_im) - AW'(old_im);

  always_ff @(posedge clk) begin
    if (rst) begin
      tot_re <= '0;
      tot_im <= '0;
      o_vld  <= 1'b0;
      o_re   <= '0;
      o_im   <= '0;
    end else if (en) begin
      o_vld <= i_vld && emit;
      if (i_vld) begin
        tot_re <= tot_re_n;
        tot_im <= tot_im_n;
        if (emit) begin
          o_re <= WO'(tot_re_n >>> SHIFT);
          o_im <= WO'(tot_im_n >>> SHIFT);
        end
      end
    end
  end
endmodule

// File: rtl/halfrate_boxcar_chain.sv
module halfrate_boxcar_chain #(
  parameter int TAPS   = 4,
  parameter int STAGES = 3,
  parameter int IN_W   = 12,
  parameter int SHIFT  = 2,
  localparam int OUT_W = boxcar_pkg::lane_width(IN_W, TAPS, SHIFT, STAGES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [IN_W-1:0]  in_re,
  input  logic signed [IN_W-1:0]  in_im,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_re,
  output logic signed [OUT_W-1:0] out_im
);
  logic adv;

  // the whole chain moves together; a held output freezes every stage
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  for (genvar k = 0; k < STAGES; k++) begin : g_st
    localparam int WI = boxcar_pkg::lane_width(IN_W, TAPS, SHIFT, k);
    localparam int WO = boxcar_pkg::lane_width(IN_W, TAPS, SHIFT, k + 1);
    logic                 vin;
    logic signed [WI-1:0] rin, iin;
    logic                 vo;
    logic signed [WO-1:0] ro, io;

    if (k == 0) begin : g_head
      assign vin = in_valid;
      assign rin = in_re;
      assign iin = in_im;
    end else begin : g_link
      assign vin = g_st[k-1].vo;
      assign rin = g_st[k-1].ro;
      assign iin = g_st[k-1].io;
    end

    boxcar_half_stage #(.TAPS(TAPS), .WI(WI), .SHIFT(SHIFT)) u_stage (
      .clk   (clk),
      .rst   (rst),
      .en    (adv),
      .i_vld (vin),
      .i_re  (rin),
      .i_im  (iin),
      .o_vld (vo),
      .o_re  (ro),
      .o_im  (io)
    );
  end

  assign out_valid = g_st[STAGES-1].vo;
  assign out_re    = g_st[STAGES-1].ro;
  assign out_im    = g_st[STAGES-1].io;
endmodule

// File: rtl/halfrate_boxcar_chain_chk.sv
module halfrate_boxcar_chain_chk #(
  parameter int STAGES = 3,
  parameter int OUT_W  = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_re,
  input logic [OUT_W-1:0] out_im
);
  logic [47:0] n_in, n_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_in  <= '0;
      n_out <= '0;
    end else begin
      if (in_valid && in_ready)   n_in  <= n_in + 1'b1;
      if (out_valid && out_ready) n_out <= n_out + 1'b1;
    end
  end

  // R1: reset leaves the output empty
  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> !out_valid);

  // R2: ready when the output slot is empty
  assert_ready_when_empty_R2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  // R2: no acceptance while the output is held
  assert_block_on_stall_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R3: a held output keeps its value
  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)));

  // R5: never more outputs than one per 2^STAGES accepted inputs
  assert_decim_ratio_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |-> (((n_out + 48'd1) << STAGES) <= n_in));
endmodule

bind halfrate_boxcar_chain halfrate_boxcar_chain_chk #(.STAGES(STAGES), .OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_re    (out_re),
  .out_im    (out_im)
);

// File: tb/halfrate_boxcar_chain_tb.sv
`timescale 1ns/1ps
module halfrate_boxcar_chain_tb;
  localparam int TAPS   = 4;
  localparam int STAGES = 3;
  localparam int IN_W   = 12;
  localparam int SHIFT  = 2;
  localparam int OUT_W  = IN_W + STAGES * ($clog2(TAPS) - SHIFT);
  localparam int RATE   = 1 << STAGES;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic signed [IN_W-1:0] in_re = '0, in_im = '0;
  logic in_ready, out_valid;
  logic signed [OUT_W-1:0] out_re, out_im;

  always #5 clk = ~clk;

  halfrate_boxcar_chain #(.TAPS(TAPS), .STAGES(STAGES), .IN_W(IN_W), .SHIFT(SHIFT)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im));

  int checks = 0, errors = 0;
  string cur_req = "R4";
  longint mre [STAGES][TAPS];
  longint mim [STAGES][TAPS];
  int     midx [STAGES];
  longint qre[$], qim[$];
  int     n_acc, n_out;
  bit     const_mode;
  longint const_val;
  bit     prev_stall;
  logic signed [OUT_W-1:0] prev_re, prev_im;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // direct window sum per stage; returns 1 when the last stage emits
  function automatic bit model_push(input longint re, input longint im,
                                    output longint ore, output longint oim);
    longint r = re, i = im;
    ore = 0; oim = 0;
    for (int s = 0; s < STAGES; s++) begin
      longint sr = 0, si = 0;
      mre[s][midx[s]] = r;
      mim[s][midx[s]] = i;
      midx[s] = (midx[s] + 1) % TAPS;
      for (int t = 0; t < TAPS; t++) begin
        sr += mre[s][t];
        si += mim[s][t];
      end
      if ((midx[s] % 2) != 0) return 1'b0;
      r = sr >>> SHIFT;
      i = si >>> SHIFT;
    end
    ore = r; oim = i;
    return 1'b1;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", longint'(in_ready), 1);
    rst = 1'b0;
    for (int s = 0; s < STAGES; s++) begin
      midx[s] = 0;
      for (int t = 0; t < TAPS; t++) begin mre[s][t] = 0; mim[s][t] = 0; end
    end
    qre.delete(); qim.delete();
    n_acc = 0; n_out = 0; prev_stall = 1'b0; const_mode = 1'b0;
  endtask

  task automatic cycle(input bit iv, input logic signed [IN_W-1:0] ire,
                       input logic signed [IN_W-1:0] iim, input bit ordy);
    longint er, ei;
    @(negedge clk);
    in_valid = iv; in_re = ire; in_im = iim; out_ready = ordy;
    #1;
    if (prev_stall) begin
      chk(out_valid == 1'b1, "R3", longint'(out_valid), 1);
      chk(out_re == prev_re && out_im == prev_im, "R3", longint'(out_re), longint'(prev_re));
    end
    chk(in_ready == (!out_valid || out_ready), "R2", longint'(in_ready),
        longint'(!out_valid || out_ready));
    if (out_valid && out_ready) begin
      n_out++;
      if (qre.size() == 0) begin
        chk(1'b0, "R5", n_out, 0);
      end else begin
        er = qre.pop_front(); ei = qim.pop_front();
        chk(longint'(out_re) == er, cur_req, longint'(out_re), er);
        chk(longint'(out_im) == ei, cur_req, longint'(out_im), ei);
        if (const_mode && n_out >= TAPS) begin
          chk(longint'(out_re) == const_val, "R7", longint'(out_re), const_val);
          chk(longint'(out_im) == -const_val - 1, "R7", longint'(out_im), -const_val - 1);
        end
      end
    end
    if (in_valid && in_ready) begin
      n_acc++;
      if (model_push(longint'(in_re), longint'(in_im), er, ei)) begin
        qre.push_back(er); qim.push_back(ei);
      end
    end
    prev_stall = out_valid && !out_ready;
    prev_re = out_re; prev_im = out_im;
  endtask

  task automatic drain();
    for (int k = 0; k < 40; k++) cycle(1'b0, '0, '0, 1'b1);
    chk(qre.size() == 0, "R5", qre.size(), 0);
  endtask

  function automatic logic signed [IN_W-1:0] rnd();
    return IN_W'($urandom);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    do_reset();

    // R4 / R5: random stream, no back-pressure, dense input
    cur_req = "R4";
    for (int k = 0; k < 64; k++) cycle(1'b1, rnd(), rnd(), 1'b1);
    drain();
    chk(n_out == 64 / RATE, "R5", n_out, 64 / RATE);

    // R2 / R3: random gaps and random back-pressure
    cur_req = "R3";
    for (int k = 0; k < 600; k++) cycle($urandom_range(0, 3) != 0, rnd(), rnd(), $urandom_range(0, 2) == 0);
    drain();
    chk(n_out * RATE <= n_acc && n_acc - n_out * RATE < RATE, "R5", n_out, n_acc / RATE);

    // R1: reset mid-stream, then history must read as zero
    for (int k = 0; k < 13; k++) cycle(1'b1, rnd(), rnd(), 1'b1);
    do_reset();
    cur_req = "R1";
    for (int k = 0; k < 24; k++) cycle(1'b1, rnd(), rnd(), 1'b1);
    drain();

    // R6: only the imaginary lane carries data, real output must stay zero
    do_reset();
    cur_req = "R6";
    for (int k = 0; k < 48; k++) cycle(1'b1, '0, rnd(), 1'b1);
    drain();

    // R7 / R8: constant full-scale inputs settle to the constant
    const_val = (1 <<< (IN_W - 1)) - 1;
    do_reset();
    cur_req = "R8"; const_mode = 1'b1;
    for (int k = 0; k < TAPS * RATE + 16; k++)
      cycle(1'b1, IN_W'(const_val), IN_W'(-const_val - 1), 1'b1);
    drain();
    const_val = -(1 <<< (IN_W - 1));
    do_reset();
    cur_req = "R8"; const_mode = 1'b1;
    for (int k = 0; k < TAPS * RATE + 16; k++)
      cycle(1'b1, IN_W'(const_val), IN_W'(-const_val - 1), 1'b1);
    drain();
    const_val = 37;
    do_reset();
    cur_req = "R7"; const_mode = 1'b1;
    for (int k = 0; k < TAPS * RATE + 8; k++)
      cycle(1'b1, IN_W'(const_val), IN_W'(-const_val - 1), $urandom_range(0, 1) == 0);
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule